// File: doc/BRIEF.md
# Transmit Host Character Buffer

This block sits between a host and the character pipeline of a serial transmitter. The host offers 9-bit characters, 8 data bits plus a command flag in bit 8, over a write strobe. A chip-enable qualifier gates that strobe. A mode input sets both the active level of the strobe and of the full flag, and it also sets whether the data travels with the strobe or one cycle after it. The characters are kept in a small circular buffer. In bypass mode they go instead through a single holding register, and the full flag then reports that the transmitter is busy.

The transmitter side pulses `char_tick` once per character time. Each pulse yields one output character one cycle later. That character is the next buffered one, or a fill character flagged by `out_sync` when there is nothing to send, when the link is halted, or when self-test mode holds off all reads. A flush input clears the buffer, but only after it has been held with the proper qualifiers for a run of consecutive cycles. The flush clears the write side first and then the read side, and the full flag stays up until the flush input is released.

Top module: `tx_host_fifo_if`

## Requirements
- R1: A write is taken only when the strobe is active in a cycle whose previous cycle sampled `host_ce_n` low; a strobe right after a cycle with `host_ce_n` high is ignored.
- R2: With `ext_mode` = 0 the strobe `host_we` is active low, and `host_data` is captured at the same clock edge that samples the strobe active.
- R3: With `ext_mode` = 1 the strobe is active high, and `host_data` is captured at the edge that follows the one sampling the strobe active.
- R4: In buffer mode (`fifo_en` = 1) the full condition holds while SLACK (4) or fewer slots remain free, and a write offered while it holds is dropped.
- R5: `full_flag` shows the full condition at level 0 when `ext_mode` = 0 and at level 1 when `ext_mode` = 1.
- R6: A flush starts only after QUAL_CYCLES (7) consecutive edges sample `flush_n` low together with `fifo_en` = 1, the strobe inactive and `host_ce_n` low; a shorter run leaves the contents intact.
- R7: A flush empties the buffer, clearing the write side before the read side. The full condition holds from the edge that starts it until the first edge that samples `flush_n` high after both sides are cleared.
- R8: In bypass mode (`fifo_en` = 0) one character is held, the full condition means that character is still waiting, further writes are dropped, and `flush_n` has no effect.
- R9: While `halt_n` is low no character is read; ticks yield fill characters, and host writes are still stored.
- R10: While `selftest_n` is low no character is read; ticks yield fill characters, and reads resume when it returns high.
- R11: Every `char_tick` pulse gives one `out_valid` pulse on the next cycle, carrying the oldest stored character in write order with `out_sync` = 0. If no read is allowed, it carries SYNC_CHAR (default 9'h17C) with `out_sync` = 1. With no tick, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | Polarity and capture-timing mode |
| fifo_en | input | 1 | 1 = buffer mode, 0 = bypass mode |
| host_ce_n | input | 1 | Chip enable, active low |
| host_we | input | 1 | Write strobe, polarity set by ext_mode |
| host_data | input | 9 | Character: bit 8 command flag, bits 7:0 data |
| flush_n | input | 1 | Buffer flush request, active low |
| halt_n | input | 1 | Halt, active low |
| selftest_n | input | 1 | Self-test enable, active low |
| char_tick | input | 1 | One pulse per character time from the transmitter |
| full_flag | output | 1 | Full / busy flag, polarity set by ext_mode |
| out_valid | output | 1 | Output character strobe |
| out_char | output | 9 | Output character |
| out_sync | output | 1 | Output character is fill |

## Verification
The bench builds the block with DEPTH = 8 and SLACK = 4, so the full condition arrives after four accepted writes. A sweep of six attempted writes therefore reaches the threshold and also tests dropping. Running the sweep twice in each strobe mode wraps both pointers more than once. The flush is exercised with runs of six and of seven qualified cycles, so both sides of the qualification boundary are covered.

// File: rtl/tx_host_pkg.sv
package tx_host_pkg;

    localparam int CHAR_W = 9;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic  valid;
        char_t ch;
    } wr_req_t;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_CLR_WR,
        FL_CLR_RD,
        FL_HOLD
    } flush_ph_e;

    // Maps between an internal active-high condition and a pin level.
    function automatic logic pin_level(input logic cond, input logic hi_mode);
        return hi_mode ? cond : ~cond;
    endfunction

endpackage

// File: rtl/tx_host_wr_if.sv
module tx_host_wr_if
    import tx_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ext_mode,
    input  logic  host_ce_n,
    input  logic  host_we,
    input  char_t host_data,
    input  logic  block,
    output wr_req_t req,
    output logic  pend,
    output logic  we_act
);
    logic ce_q;
    logic sel;

    assign we_act = pin_level(host_we, ext_mode);
    assign sel    = we_act && ce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= 1'b0;
            pend <= 1'b0;
        end else begin
            ce_q <= ~host_ce_n;
            pend <= ext_mode && sel && !block;
        end
    end

    always_comb begin
        req.valid = pend || (!ext_mode && sel && !block);
        req.ch    = host_data;
    end
endmodule

// File: rtl/tx_host_flush_seq.sv
module tx_host_flush_seq
    import tx_host_pkg::*;
#(
    parameter int QUAL_CYCLES = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en,
    input  logic flush_n,
    input  logic we_act,
    input  logic host_ce_n,
    output logic clr_wr,
    output logic clr_rd,
    output logic busy
);
    localparam int QW = $clog2(QUAL_CYCLES + 1);

    flush_ph_e     ph;
    logic [QW-1:0] run;
    logic          qual;

    assign qual = fifo_en && !flush_n && !we_act && !host_ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= FL_IDLE;
            run <= '0;
        end else begin
            unique case (ph)
                FL_IDLE: begin
                    if (qual) begin
                        if (run == QW'(QUAL_CYCLES - 1)) begin
                            ph  <= FL_CLR_WR;
                            run <= '0;
                        end else begin
                            run <= run + 1'b1;
                        end
                    end else begin
                        run <= '0;
                    end
                end
                FL_CLR_WR: ph <= FL_CLR_RD;
                FL_CLR_RD: ph <= FL_HOLD;
                FL_HOLD:   if (flush_n) ph <= FL_IDLE;
                default:   ph <= FL_IDLE;
            endcase
        end
    end

    assign clr_wr = (ph == FL_CLR_WR);
    assign clr_rd = (ph == FL_CLR_RD);
    assign busy   = (ph != FL_IDLE);
endmodule

// File: rtl/tx_host_char_buf.sv
module tx_host_char_buf
    import tx_host_pkg::*;
#(
    parameter int    DEPTH     = 16,
    parameter int    SLACK     = 4,
    parameter char_t SYNC_CHAR = 9'h17C
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fifo_en,
    input  wr_req_t req,
    input  logic    pend,
    input  logic    clr_wr,
    input  logic    clr_rd,
    input  logic    flush_busy,
    input  logic    halt_n,
    input  logic    selftest_n,
    input  logic    char_tick,
    output logic    full_int,
    output logic [$clog2(DEPTH):0] occ,
    output logic    out_valid,
    output char_t   out_char,
    output logic    out_sync
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(DEPTH - SLACK);

    char_t             mem [DEPTH];
    logic [CNT_W-1:0]  wr_ptr, rd_ptr;
    logic              hold_v;
    char_t             hold_d;
    logic              have_data;
    logic              rd_ok;
    logic              push_fifo, push_hold;

    assign occ = wr_ptr - rd_ptr;

    always_comb begin
        if (fifo_en) full_int = flush_busy || ((occ + CNT_W'(pend)) >= FULL_AT);
        else         full_int = hold_v || pend;
    end

    assign have_data = fifo_en ? (occ != '0) : hold_v;
    assign rd_ok     = char_tick && halt_n && selftest_n && !flush_busy && have_data;
    assign push_fifo = req.valid && fifo_en && !flush_busy;
    assign push_hold = req.valid && !fifo_en;

    always_ff @(posedge clk) begin
        if (push_fifo) mem[wr_ptr[PTR_W-1:0]] <= req.ch;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_wr)     wr_ptr <= '0;
        else if (push_fifo)    wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_rd)         rd_ptr <= '0;
        else if (rd_ok && fifo_en) rd_ptr <= rd_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (push_hold) begin
            hold_v <= 1'b1;
            hold_d <= req.ch;
        end else if (rd_ok && !fifo_en) begin
            hold_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_char  <= '0;
            out_sync  <= 1'b0;
        end else begin
            out_valid <= char_tick;
            out_sync  <= char_tick && !rd_ok;
            if (char_tick) begin
                if (!rd_ok)       out_char <= SYNC_CHAR;
                else if (fifo_en) out_char <= mem[rd_ptr[PTR_W-1:0]];
                else              out_char <= hold_d;
            end
        end
    end
endmodule

// File: rtl/tx_host_fifo_if.sv
module tx_host_fifo_if
    import tx_host_pkg::*;
#(
    parameter int    DEPTH       = 16,
    parameter int    SLACK       = 4,
    parameter int    QUAL_CYCLES = 7,
    parameter char_t SYNC_CHAR   = 9'h17C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    input  logic       fifo_en,
    input  logic       host_ce_n,
    input  logic       host_we,
    input  logic [8:0] host_data,
    input  logic       flush_n,
    input  logic       halt_n,
    input  logic       selftest_n,
    input  logic       char_tick,
    output logic       full_flag,
    output logic       out_valid,
    output logic [8:0] out_char,
    output logic       out_sync
);
    wr_req_t              req;
    logic                 pend, we_act;
    logic                 clr_wr, clr_rd, flush_busy;
    logic                 full_int;
    logic [$clog2(DEPTH):0] occ;

    tx_host_wr_if u_wr (
        .clk, .rst, .ext_mode, .host_ce_n, .host_we,
        .host_data (host_data),
        .block     (full_int),
        .req, .pend, .we_act
    );

    tx_host_flush_seq #(.QUAL_CYCLES(QUAL_CYCLES)) u_flush (
        .clk, .rst, .fifo_en, .flush_n, .we_act, .host_ce_n,
        .clr_wr, .clr_rd,
        .busy (flush_busy)
    );

    tx_host_char_buf #(.DEPTH(DEPTH), .SLACK(SLACK), .SYNC_CHAR(SYNC_CHAR)) u_buf (
        .clk, .rst, .fifo_en, .req, .pend, .clr_wr, .clr_rd, .flush_busy,
        .halt_n, .selftest_n, .char_tick, .full_int, .occ,
        .out_valid, .out_char, .out_sync
    );

    assign full_flag = pin_level(full_int, ext_mode);
endmodule

// File: rtl/tx_host_fifo_if_chk.sv
module tx_host_fifo_if_chk #(
    parameter int DEPTH = 16,
    parameter int SLACK = 4
) (
    input logic clk,
    input logic rst,
    input logic fifo_en,
    input logic flush_n,
    input logic halt_n,
    input logic selftest_n,
    input logic char_tick,
    input logic out_valid,
    input logic out_sync,
    input logic flush_busy,
    input logic [$clog2(DEPTH):0] occ
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(DEPTH - SLACK);

    a_r11_tick_strobe: assert property (@(posedge clk) disable iff (rst)
        char_tick |=> out_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !char_tick |=> !out_valid);
    a_r9_halt_fill: assert property (@(posedge clk) disable iff (rst)
        (!halt_n && char_tick) |=> out_sync);
    a_r10_selftest_fill: assert property (@(posedge clk) disable iff (rst)
        (!selftest_n && char_tick) |=> out_sync);
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !flush_busy) |-> (occ <= FULL_AT));
    a_r8_bypass_no_flush: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !flush_busy) |=> !flush_busy);
    a_r6_flush_needs_request: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_busy) |-> $past(!flush_n));
    a_r7_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && !flush_n) |=> flush_busy);
endmodule

bind tx_host_fifo_if tx_host_fifo_if_chk #(.DEPTH(DEPTH), .SLACK(SLACK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .flush_n    (flush_n),
    .halt_n     (halt_n),
    .selftest_n (selftest_n),
    .char_tick  (char_tick),
    .out_valid  (out_valid),
    .out_sync   (out_sync),
    .flush_busy (flush_busy),
    .occ        (occ)
);

// File: tb/tx_host_fifo_if_tb.sv
`timescale 1ns/1ps
module tx_host_fifo_if_tb;
    localparam int DEPTH   = 8;
    localparam int SLACK   = 4;
    localparam int FULL_AT = DEPTH - SLACK;
    localparam logic [8:0] SYNC = 9'h17C;

    logic clk = 1'b0;
    logic rst, ext_mode, fifo_en, host_ce_n, host_we, flush_n, halt_n, selftest_n, char_tick;
    logic [8:0] host_data;
    logic full_flag, out_valid, out_sync;
    logic [8:0] out_char;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [8:0] mq[$];

    always #2.5 clk = ~clk;

    tx_host_fifo_if #(.DEPTH(DEPTH), .SLACK(SLACK), .QUAL_CYCLES(7), .SYNC_CHAR(SYNC)) u_dut (
        .clk, .rst, .ext_mode, .fifo_en, .host_ce_n, .host_we, .host_data,
        .flush_n, .halt_n, .selftest_n, .char_tick,
        .full_flag, .out_valid, .out_char, .out_sync
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flag level expected for a given internal full condition (R5).
    function automatic logic flag_of(input logic full);
        return ext_mode ? full : ~full;
    endfunction

    function automatic logic we_idle();
        return ext_mode ? 1'b0 : 1'b1;
    endfunction

    // Buffer-mode write with model update.
    task automatic write_char(input logic [8:0] d, input string req);
        bit acc;
        acc = fifo_en ? (mq.size() < FULL_AT) : (mq.size() == 0);
        if (!ext_mode) begin
            host_we = 1'b0; host_data = d; step();
            host_we = 1'b1;
        end else begin
            host_we = 1'b1; step();
            host_we = 1'b0; host_data = d; step();
        end
        if (acc) mq.push_back(d);
        if (fifo_en) check(req, full_flag, flag_of(mq.size() >= FULL_AT));
        else         check(req, full_flag, flag_of(mq.size() != 0));
    endtask

    task automatic tick_expect(input bit allow, input string req);
        logic [8:0] e;
        bit         s;
        char_tick = 1'b1; step(); char_tick = 1'b0;
        if (allow && mq.size() != 0) begin e = mq.pop_front(); s = 1'b0; end
        else begin e = SYNC; s = 1'b1; end
        check(req, out_valid, 1'b1);
        check(req, out_char, e);
        check(req, out_sync, s);
        step();
        check(req, out_valid, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; ext_mode = 0; fifo_en = 1; host_ce_n = 0; host_we = 1;
        host_data = '0; flush_n = 1; halt_n = 1; selftest_n = 1; char_tick = 0;
        repeat (3) step();
        rst = 0; step();
        check("reset R5", full_flag, 1'b1);
        check("reset R11", out_valid, 1'b0);

        // R2 R3 R4 R5 R11: fill sweeps in both strobe modes, twice each to wrap
        for (int m = 0; m < 2; m++) begin
            ext_mode = m[0]; host_we = we_idle(); step();
            for (int rep = 0; rep < 2; rep++) begin
                for (int k = 0; k < FULL_AT + 2; k++)
                    write_char(9'((m * 64 + rep * 16 + k) * 37 + 5), m ? "R3 R4 R5" : "R2 R4 R5");
                for (int k = 0; k < FULL_AT + 1; k++)
                    tick_expect(1, "R11 order");
            end
        end
        ext_mode = 0; host_we = 1; step();

        // R1: strobe right after a cycle with chip enable high is ignored
        host_ce_n = 1; step(); step();
        host_ce_n = 0; host_we = 0; host_data = 9'h0AA; step();
        host_we = 1; step();
        tick_expect(1, "R1 ce gating");
        write_char(9'h155, "R1 ce low before");
        tick_expect(1, "R1 ce low before");

        // R9: halt emits fill while writes still land
        write_char(9'h011, "R9");
        write_char(9'h122, "R9");
        halt_n = 0;
        tick_expect(0, "R9 halted");
        write_char(9'h033, "R9 write while halted");
        tick_expect(0, "R9 halted");
        halt_n = 1;
        for (int k = 0; k < 4; k++) tick_expect(1, "R9 resumed");

        // R10: self-test suspends reads
        write_char(9'h044, "R10");
        selftest_n = 0;
        tick_expect(0, "R10 selftest");
        tick_expect(0, "R10 selftest");
        selftest_n = 1;
        tick_expect(1, "R10 resumed");

        // R6: six qualified cycles leave contents intact
        write_char(9'h0C1, "R6");
        write_char(9'h0C2, "R6");
        flush_n = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            check("R6 short run", full_flag, flag_of(1'b0));
        end
        flush_n = 1; step();
        tick_expect(1, "R6 contents kept");

        // R7: seven qualified cycles flush; full held while input low
        flush_n = 0;
        for (int k = 1; k <= 7; k++) begin
            step();
            check("R6 R7 qualify", full_flag, flag_of(k == 7));
        end
        for (int k = 0; k < 3; k++) begin
            step();
            check("R7 held", full_flag, flag_of(1'b1));
        end
        flush_n = 1; step();
        check("R7 release", full_flag, flag_of(1'b0));
        mq.delete();
        tick_expect(1, "R7 emptied");
        write_char(9'h0D7, "R7 after flush");
        tick_expect(1, "R7 after flush");

        // R8: bypass holding register, both modes; flush ignored
        fifo_en = 0;
        for (int m = 0; m < 2; m++) begin
            ext_mode = m[0]; host_we = we_idle(); step();
            write_char(9'h101 + 9'(m), "R8 hold");
            write_char(9'h0EE, "R8 dropped");
            tick_expect(1, "R8 hold out");
            check("R8 busy clear", full_flag, flag_of(1'b0));
            tick_expect(1, "R8 empty");
        end
        ext_mode = 0; host_we = 1; step();
        write_char(9'h0F3, "R8 flush ignored");
        flush_n = 0;
        for (int k = 0; k < 10; k++) step();
        check("R8 flush ignored", full_flag, flag_of(1'b1));
        flush_n = 1; step();
        tick_expect(1, "R8 flush ignored");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule